// File: doc/BRIEF.md
# Adapter Bus Control and Shared-Window Decoder

This block sits on the host side of a plug-in serial adapter. It answers four byte-wide I/O ports placed at a parameterised base address. Through these ports software can open and place a paged 16 KB window onto the card's shared RAM, pick how RAM cycles are run, and route the communications controller's interrupt to one of seven host IRQ lines. Software can also pulse the controller's reset.

Host memory cycles are decoded against the programmed window. The window can sit in one of two address zones. In the low zone it is placed in 16 KB steps above 0x80000. In the high zone it is placed at 256 KB steps above 0xC00000. The low 14 address bits pass straight through to the local RAM, and a 4-bit page number supplies the rest. The interrupt can be routed as an active-high edge-style signal, or as an active-low level that is driven only while asserted, so that several cards can share one line.

Top module: `adp_bus_ctrl`

## Requirements
- R1: After a synchronous reset, the port at offset 0 reads 0x00 and the window is closed. No IRQ line is enabled, the low zone is selected, `ram_zws` and `ram_wide` are 0, `reg_access_en` is 1 and `ctl_rst` is 1.
- R2: A port access counts only when `host_addr[9:2]` equals `IO_BASE[9:2]`. A write at any other address has no effect, and a read at any other address leaves `io_rdata_en` low.
- R3: Offset 0 reads back the last byte written to it. In that byte, bit 7 opens the window, bit 6 set drives `reg_access_en` to 0, and bits 3:0 are the RAM page.
- R4: `ram_addr` equals {page[3:0], host_addr[13:0]}.
- R5: In the low zone (offset 2 bit 7 = 0), the window covers the 16 KB that starts at 0x80000 + P×0x4000, where P is offset 1 bits 4:0.
- R6: In the high zone (offset 2 bit 7 = 1), the window covers the first 16 KB of the region at 0xC00000 + Q×0x40000, where Q is offset 1 bits 4:1. Offset 1 bit 0 has no effect in this zone.
- R7: `ram_sel` is 1 only while `mem_rd` or `mem_wr` is high, the window is open, and `host_addr` is inside the window.
- R8: Offset 2 bit 6 drives `ram_zws` and offset 2 bit 5 drives `ram_wide`.
- R9: Offset 1 bits 7:5 choose the IRQ line. Code 0 chooses none. Codes 1 to 7 choose `irq_out`/`irq_oe` index code−1, and the indices map in order to IRQ3, 4, 9, 10, 11, 12 and 15.
- R10: With offset 2 bit 4 = 1 (edge style), the chosen line has `irq_oe`=1 and `irq_out`=`ctl_irq`. With bit 4 = 0 (shared level), the chosen line has `irq_oe`=`ctl_irq` and `irq_out`=0. Lines that are not chosen always have `irq_oe`=0 and `irq_out`=0.
- R11: Every write to offset 3 inverts `ctl_rst` in the next cycle, whatever the data.
- R12: A read of offset 3 returns {jumper_v35, 0, ctl_irq, ctl_rst, slot_wide, 000} from bit 7 down. Reads of offsets 1 and 2 leave `io_rdata_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 24 | Host address, used for both port and memory cycles |
| host_wdata | input | 8 | Host write data for port writes |
| io_rd | input | 1 | Port read strobe |
| io_wr | input | 1 | Port write strobe, sampled on the clock edge |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| jumper_v35 | input | 1 | Header jumper fitted |
| slot_wide | input | 1 | 1 when the card sits in a 16-bit slot |
| ctl_irq | input | 1 | Interrupt from the communications controller |
| io_rdata | output | 8 | Port read data |
| io_rdata_en | output | 1 | Drive enable for `io_rdata` |
| ram_addr | output | 18 | Local RAM address |
| ram_sel | output | 1 | Local RAM select |
| ram_zws | output | 1 | Zero-wait-state RAM cycles enabled |
| ram_wide | output | 1 | 16-bit RAM transfers enabled |
| reg_access_en | output | 1 | Host access to controller registers allowed |
| ctl_rst | output | 1 | Reset to the communications controller |
| irq_out | output | 7 | IRQ line values |
| irq_oe | output | 7 | IRQ line drive enables |

## Verification
The assertions check, on every cycle, that at most one IRQ line is driven and that no line carries a high value without its enable. They also check that `ram_sel` and `io_rdata_en` appear only with their strobes, and that `ctl_rst` changes exactly when offset 3 is written. Only the bench's sweeps can show the placement arithmetic: every window position in both zones with its edge addresses, the page steering, the IRQ code map in both styles, the status byte, and the fact that writes to other addresses are ignored.

// File: rtl/adp_pkg.sv
package adp_pkg;
    localparam int HADDR_W = 24;
    localparam int OFF_W   = 14;
    localparam int PAGE_W  = 4;
    localparam int PLACE_W = 5;
    localparam int IRQ_N   = 7;
    localparam int CODE_W  = $clog2(IRQ_N + 1);
    localparam int RAM_AW  = PAGE_W + OFF_W;

    typedef enum logic [1:0] {
        OFS_WIN  = 2'd0,
        OFS_MAP  = 2'd1,
        OFS_MODE = 2'd2,
        OFS_RST  = 2'd3
    } ofs_e;

    typedef struct packed {
        logic hi_zone;
        logic zws;
        logic wide;
        logic edge_irq;
    } mode_t;

    // Window match for both zones; window length is 2**OFF_W bytes.
    function automatic logic win_hit(input logic [HADDR_W-1:0] a,
                                     input logic hi,
                                     input logic [PLACE_W-1:0] place);
        if (hi)
            return (a[23:22] == 2'b11) && (a[21:18] == place[4:1]) &&
                   (a[17:OFF_W] == '0);
        else
            return (a[23:20] == 4'h0) && a[19] && (a[18:OFF_W] == place);
    endfunction
endpackage

// File: rtl/adp_io_regs.sv
module adp_io_regs
    import adp_pkg::*;
#(
    parameter int IO_AW = 10,
    parameter logic [IO_AW-1:0] IO_BASE = 10'h2A0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [7:0]           wdata,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic                 jumper_v35,
    input  logic                 slot_wide,
    input  logic                 ctl_irq,
    output logic                 win_on,
    output logic                 reg_block,
    output logic [PAGE_W-1:0]    page,
    output logic [PLACE_W-1:0]   place,
    output logic [CODE_W-1:0]    irq_code,
    output mode_t                mode,
    output logic                 ctl_rst,
    output logic [7:0]           rdata,
    output logic                 rdata_en
);
    logic [7:0] win_q;
    logic [7:0] map_q;
    logic       sel;
    ofs_e       ofs;

    assign sel = (io_addr[IO_AW-1:2] == IO_BASE[IO_AW-1:2]);
    assign ofs = ofs_e'(io_addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= '0;
            map_q   <= '0;
            mode    <= '0;
            ctl_rst <= 1'b1;
        end else if (io_wr && sel) begin
            unique case (ofs)
                OFS_WIN:  win_q   <= wdata;
                OFS_MAP:  map_q   <= wdata;
                OFS_MODE: mode    <= mode_t'(wdata[7:4]);
                OFS_RST:  ctl_rst <= ~ctl_rst;
            endcase
        end
    end

    assign win_on    = win_q[7];
    assign reg_block = win_q[6];
    assign page      = win_q[PAGE_W-1:0];
    assign place     = map_q[PLACE_W-1:0];
    assign irq_code  = map_q[7:8-CODE_W];

    always_comb begin
        rdata    = '0;
        rdata_en = 1'b0;
        if (io_rd && sel) begin
            if (ofs == OFS_WIN) begin
                rdata    = win_q;
                rdata_en = 1'b1;
            end else if (ofs == OFS_RST) begin
                rdata    = {jumper_v35, 1'b0, ctl_irq, ctl_rst, slot_wide, 3'b000};
                rdata_en = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adp_win_dec.sv
module adp_win_dec
    import adp_pkg::*;
(
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic               win_on,
    input  logic               hi_zone,
    input  logic [PAGE_W-1:0]  page,
    input  logic [PLACE_W-1:0] place,
    output logic               ram_sel,
    output logic [RAM_AW-1:0]  ram_addr
);
    assign ram_sel  = (mem_rd || mem_wr) && win_on && win_hit(host_addr, hi_zone, place);
    assign ram_addr = {page, host_addr[OFF_W-1:0]};
endmodule

// File: rtl/adp_irq_steer.sv
module adp_irq_steer
    import adp_pkg::*;
(
    input  logic [CODE_W-1:0] irq_code,
    input  logic              edge_irq,
    input  logic              ctl_irq,
    output logic [IRQ_N-1:0]  irq_out,
    output logic [IRQ_N-1:0]  irq_oe
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        logic chosen;
        assign chosen     = (irq_code == CODE_W'(i + 1));
        assign irq_oe[i]  = chosen && (edge_irq || ctl_irq);
        assign irq_out[i] = chosen && edge_irq && ctl_irq;
    end
endmodule

// File: rtl/adp_bus_ctrl.sv
module adp_bus_ctrl
    import adp_pkg::*;
#(
    parameter int IO_AW = 10,
    parameter logic [IO_AW-1:0] IO_BASE = 10'h2A0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HADDR_W-1:0]  host_addr,
    input  logic [7:0]          host_wdata,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic                mem_rd,
    input  logic                mem_wr,
    input  logic                jumper_v35,
    input  logic                slot_wide,
    input  logic                ctl_irq,
    output logic [7:0]          io_rdata,
    output logic                io_rdata_en,
    output logic [RAM_AW-1:0]   ram_addr,
    output logic                ram_sel,
    output logic                ram_zws,
    output logic                ram_wide,
    output logic                reg_access_en,
    output logic                ctl_rst,
    output logic [IRQ_N-1:0]    irq_out,
    output logic [IRQ_N-1:0]    irq_oe
);
    logic               win_on;
    logic               reg_block;
    logic [PAGE_W-1:0]  page;
    logic [PLACE_W-1:0] place;
    logic [CODE_W-1:0]  irq_code;
    mode_t              mode;

    adp_io_regs #(.IO_AW(IO_AW), .IO_BASE(IO_BASE)) u_regs (
        .clk(clk), .rst(rst),
        .io_addr(host_addr[IO_AW-1:0]), .wdata(host_wdata),
        .io_rd(io_rd), .io_wr(io_wr),
        .jumper_v35(jumper_v35), .slot_wide(slot_wide), .ctl_irq(ctl_irq),
        .win_on(win_on), .reg_block(reg_block), .page(page), .place(place),
        .irq_code(irq_code), .mode(mode), .ctl_rst(ctl_rst),
        .rdata(io_rdata), .rdata_en(io_rdata_en)
    );

    adp_win_dec u_win (
        .host_addr(host_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .win_on(win_on), .hi_zone(mode.hi_zone), .page(page), .place(place),
        .ram_sel(ram_sel), .ram_addr(ram_addr)
    );

    adp_irq_steer u_irq (
        .irq_code(irq_code), .edge_irq(mode.edge_irq), .ctl_irq(ctl_irq),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    assign ram_zws       = mode.zws;
    assign ram_wide      = mode.wide;
    assign reg_access_en = ~reg_block;
endmodule

// File: rtl/adp_chk.sv
module adp_chk #(
    parameter int IO_AW = 10,
    parameter logic [IO_AW-1:0] IO_BASE = 10'h2A0
) (
    input logic             clk,
    input logic             rst,
    input logic [IO_AW-1:0] io_addr,
    input logic             io_rd,
    input logic             io_wr,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             io_rdata_en,
    input logic             ram_sel,
    input logic             ctl_rst,
    input logic [6:0]       irq_out,
    input logic [6:0]       irq_oe
);
    logic rst_port_wr;
    assign rst_port_wr = io_wr && (io_addr[IO_AW-1:2] == IO_BASE[IO_AW-1:2]) &&
                         (io_addr[1:0] == 2'd3);

    // R11
    rst_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        rst_port_wr |=> (ctl_rst != $past(ctl_rst)));

    // R11
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_port_wr |=> $stable(ctl_rst));

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_oe));

    // R10
    irq_undriven_high_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_out) |-> ((irq_out & ~irq_oe) == 7'd0));

    // R7
    ram_sel_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> (mem_rd || mem_wr));

    // R2
    rdata_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        io_rdata_en |-> io_rd);
endmodule

bind adp_bus_ctrl adp_chk #(.IO_AW(IO_AW), .IO_BASE(IO_BASE)) u_chk (
    .clk(clk), .rst(rst), .io_addr(host_addr[IO_AW-1:0]),
    .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rdata_en(io_rdata_en), .ram_sel(ram_sel), .ctl_rst(ctl_rst),
    .irq_out(irq_out), .irq_oe(irq_oe)
);

// File: tb/tb_adp_bus_ctrl.sv
module tb_adp_bus_ctrl;
    localparam logic [23:0] BASE = 24'h0002A0;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] host_addr;
    logic [7:0]  host_wdata;
    logic        io_rd, io_wr, mem_rd, mem_wr;
    logic        jumper_v35, slot_wide, ctl_irq;
    logic [7:0]  io_rdata;
    logic        io_rdata_en;
    logic [17:0] ram_addr;
    logic        ram_sel, ram_zws, ram_wide, reg_access_en, ctl_rst;
    logic [6:0]  irq_out, irq_oe;

    int nchk = 0;
    int nfail = 0;

    adp_bus_ctrl dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .jumper_v35(jumper_v35), .slot_wide(slot_wide), .ctl_irq(ctl_irq),
        .io_rdata(io_rdata), .io_rdata_en(io_rdata_en), .ram_addr(ram_addr),
        .ram_sel(ram_sel), .ram_zws(ram_zws), .ram_wide(ram_wide),
        .reg_access_en(reg_access_en), .ctl_rst(ctl_rst),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [23:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        host_addr = a; io_rd = 1'b1;
        #2;
        d = io_rdata; en = io_rdata_en;
        io_rd = 1'b0;
    endtask

    task automatic mem_probe(input logic [23:0] a, output logic sel, output logic [17:0] ra);
        @(negedge clk);
        host_addr = a; mem_rd = 1'b1;
        #2;
        sel = ram_sel; ra = ram_addr;
        mem_rd = 1'b0;
    endtask

    // Window placement from the requirement arithmetic (R5, R6)
    function automatic logic [31:0] win_base(input logic hi, input int code);
        if (hi) return 32'hC00000 + (code / 2) * 32'h40000;
        return 32'h80000 + code * 32'h4000;
    endfunction

    task automatic sweep_zone(input logic hi, input string tag);
        logic        s;
        logic [17:0] ra;
        logic [31:0] b;
        logic [31:0] probe [4];
        for (int code = 0; code < 32; code++) begin
            io_write(BASE + 24'd0, 8'h80 | 8'(code % 16));
            io_write(BASE + 24'd1, 8'(code));
            b = win_base(hi, code);
            probe[0] = b; probe[1] = b + 32'h3FFF;
            probe[2] = b - 32'd1; probe[3] = b + 32'h4000;
            for (int k = 0; k < 4; k++) begin
                mem_probe(probe[k][23:0], s, ra);
                chk(tag, {31'd0, s}, {31'd0, (probe[k] >= b) && (probe[k] < b + 32'h4000)});
                chk("R4 ram_addr", {14'd0, ra}, {14'd0, 4'(code % 16), probe[k][13:0]});
            end
        end
    endtask

    initial begin
        logic [7:0]  d;
        logic        en, s;
        logic [17:0] ra;
        logic [6:0]  exp_oe, exp_out;

        rst = 1'b1; host_addr = '0; host_wdata = '0;
        io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0;
        jumper_v35 = 0; slot_wide = 0; ctl_irq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        io_read(BASE, d, en);
        chk("R1 reg0 after reset", {23'd0, en, d}, {23'd0, 1'b1, 8'h00});
        chk("R1 ctl_rst", {31'd0, ctl_rst}, 32'd1);
        chk("R1 reg_access_en", {31'd0, reg_access_en}, 32'd1);
        chk("R1 zws/wide", {30'd0, ram_zws, ram_wide}, 32'd0);
        ctl_irq = 1'b1; #1;
        chk("R1 no irq", {25'd0, irq_oe}, 32'd0);
        ctl_irq = 1'b0;
        mem_probe(24'h080000, s, ra);
        chk("R1 window closed", {31'd0, s}, 32'd0);

        // R3 readback and register-access gate
        io_write(BASE, 8'hC7);
        io_read(BASE, d, en);
        chk("R3 readback", {24'd0, d}, 32'hC7);
        chk("R3 reg_access_en", {31'd0, reg_access_en}, 32'd0);
        io_write(BASE, 8'h35);
        io_read(BASE, d, en);
        chk("R3 readback2", {24'd0, d}, 32'h35);
        chk("R3 reg_access_en2", {31'd0, reg_access_en}, 32'd1);

        // R2 writes away from the base are ignored
        io_write(BASE + 24'd4, 8'hFF);
        io_write(BASE ^ 24'h100, 8'hAA);
        io_read(BASE, d, en);
        chk("R2 ignored write", {24'd0, d}, 32'h35);
        io_read(BASE + 24'd4, d, en);
        chk("R2 foreign read", {31'd0, en}, 32'd0);

        // R12 write-only ports do not drive
        io_read(BASE + 24'd1, d, en);
        chk("R12 ofs1 undriven", {31'd0, en}, 32'd0);
        io_read(BASE + 24'd2, d, en);
        chk("R12 ofs2 undriven", {31'd0, en}, 32'd0);

        // R5 low zone sweep, R6 high zone sweep
        io_write(BASE + 24'd2, 8'h00);
        sweep_zone(1'b0, "R5 low zone hit");
        io_write(BASE + 24'd2, 8'h80);
        sweep_zone(1'b1, "R6 high zone hit");

        // R7 window closed or no strobe
        io_write(BASE + 24'd2, 8'h00);
        io_write(BASE + 24'd1, 8'h03);
        io_write(BASE, 8'h02);
        mem_probe(24'h08C000, s, ra);
        chk("R7 closed window", {31'd0, s}, 32'd0);
        io_write(BASE, 8'h82);
        @(negedge clk); host_addr = 24'h08C010; #2;
        chk("R7 no strobe", {31'd0, ram_sel}, 32'd0);
        mem_wr = 1'b1; #1;
        chk("R7 write strobe", {31'd0, ram_sel}, 32'd1);
        mem_wr = 1'b0;

        // R8 cycle options
        io_write(BASE + 24'd2, 8'h60); #1;
        chk("R8 zws+wide", {30'd0, ram_zws, ram_wide}, 32'd3);
        io_write(BASE + 24'd2, 8'h40); #1;
        chk("R8 zws only", {30'd0, ram_zws, ram_wide}, 32'd2);
        io_write(BASE + 24'd2, 8'h20); #1;
        chk("R8 wide only", {30'd0, ram_zws, ram_wide}, 32'd1);

        // R9 and R10 code map in both styles
        for (int edge_m = 0; edge_m < 2; edge_m++) begin
            io_write(BASE + 24'd2, edge_m ? 8'h10 : 8'h00);
            for (int code = 0; code < 8; code++) begin
                io_write(BASE + 24'd1, 8'(code << 5));
                for (int ci = 0; ci < 2; ci++) begin
                    @(negedge clk); ctl_irq = 1'(ci); #2;
                    exp_oe = '0; exp_out = '0;
                    if (code != 0) begin
                        if (edge_m != 0) begin
                            exp_oe  = 7'(1 << (code - 1));
                            exp_out = ci ? exp_oe : 7'd0;
                        end else begin
                            exp_oe  = ci ? 7'(1 << (code - 1)) : 7'd0;
                        end
                    end
                    chk(edge_m ? "R10 edge oe" : "R10 level oe", {25'd0, irq_oe}, {25'd0, exp_oe});
                    chk("R9 line value", {25'd0, irq_out}, {25'd0, exp_out});
                end
            end
        end
        ctl_irq = 1'b0;

        // R11 toggle reset, R12 status byte
        io_write(BASE + 24'd3, 8'h5A);
        chk("R11 first write releases", {31'd0, ctl_rst}, 32'd0);
        io_write(BASE + 24'd3, 8'h00);
        chk("R11 second write asserts", {31'd0, ctl_rst}, 32'd1);
        io_write(BASE + 24'd3, 8'hFF);
        chk("R11 third write releases", {31'd0, ctl_rst}, 32'd0);
        for (int m = 0; m < 8; m++) begin
            jumper_v35 = m[0]; slot_wide = m[1]; ctl_irq = m[2];
            io_read(BASE + 24'd3, d, en);
            chk("R12 status", {23'd0, en, d},
                {23'd0, 1'b1, 1'(m & 1), 1'b0, 1'((m >> 2) & 1), 1'b0, 1'((m >> 1) & 1), 3'b000});
        end
        io_write(BASE + 24'd3, 8'h11);
        io_read(BASE + 24'd3, d, en);
        chk("R12 status reset bit", {31'd0, d[4]}, 32'd1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        nchk++; nfail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule